// File: doc/BRIEF.md
# Burst Gate Suppression Sequencer

This block turns a once-per-line horizontal strobe into two timing pulses. The first is a horizontal pulse that runs on every line without a break. The second is a burst gate that sits in the tail of the horizontal pulse and ends together with it. The block also outputs a two-bit code for a three-level sandcastle, which an analog stage outside the block turns into voltages.

The burst gate is blanked for a run of lines whenever the head-switch input changes level, on either edge. A vertical-detect strobe resets a line counter and toggles a field flag. If that strobe arrives while blanking is in force, the blanking is stretched until the line counter reaches a field-dependent target line. The whole blanked stretch always covers an even number of lines. When the count would be odd, the block blanks one more line.

The burst position inside the line and the pulse widths are set in clock cycles by parameters. The run length and the two target lines are parameters too.

Top module: `burst_gate_seq`

## Requirements
- R1: While reset is asserted and right after it, burst_gate and hpulse are low and sc_code is 2'b00; the stored head-switch level resets to 0.
- R2: hpulse is high for exactly HP_CYCLES (default 8) clock cycles starting in the cycle after a cycle in which hstrobe is high, on every line, including blanked lines.
- R3: On a line that is not blanked, burst_gate is high from line cycle GATE_START (default 4) through line cycle HP_CYCLES-1, and it falls in the same cycle as hpulse. Line cycle 0 is the first cycle of hpulse.
- R4: sc_code is 2'b10 while burst_gate is high, 2'b01 while only hpulse is high, and 2'b00 otherwise.
- R5: A rising or falling edge of head_sw, sampled before a line's hstrobe, blanks the burst gate on the following RUN_LINES (default 16) lines.
- R6: A head_sw edge during a blanked run reloads the run to RUN_LINES further lines.
- R7: A vdet pulse during blanking, or in the same cycle as a head_sw edge, keeps the gate blanked on every line whose number is below the target. A line's number is the count of hstrobes since the last vdet, so the line numbered at the target is the first one not blanked by this extension.
- R8: The target is 12 after the first vdet following reset, 324 after the second, and then alternates with each vdet.
- R9: A continuous blanked stretch always spans an even number of lines: when it would end after an odd count, exactly one extra line is blanked.
- R10: A vdet pulse while no blanking is in force does not blank any line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hstrobe | input | 1 | One-cycle strobe at the start of each line |
| head_sw | input | 1 | Head-switch level; both edges start blanking |
| vdet | input | 1 | One-cycle vertical-detect strobe |
| burst_gate | output | 1 | Burst gating pulse |
| hpulse | output | 1 | Uninterrupted horizontal pulse |
| sc_code | output | 2 | Sandcastle level: 10 high, 01 intermediate, 00 low |

## Verification
A head-switch edge and a vertical-detect strobe can land in the same clock cycle. In that cycle the block must both load a new run and decide whether to stretch it. The bench drives the two inputs on the same clock edge in the second field. It then expects 323 lines blanked by the extension plus one parity line, 324 in all, before the first gated line. A run that started and stretched on separate cycles is measured in the same way for comparison.

// File: rtl/burst_gate_seq.sv
module burst_gate_seq #(
  parameter int LINE_W     = 10,
  parameter int RUN_LINES  = 16,
  parameter int EXT_LINE_A = 12,
  parameter int EXT_LINE_B = 324,
  parameter int HP_CYCLES  = 8,
  parameter int GATE_START = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hstrobe,
  input  logic       head_sw,
  input  logic       vdet,
  output logic       burst_gate,
  output logic       hpulse,
  output logic [1:0] sc_code
);
  localparam int POS_W = $clog2(HP_CYCLES + 1);
  localparam int RUN_W = $clog2(RUN_LINES + 1);
  localparam logic [POS_W-1:0]  POS_END = POS_W'(HP_CYCLES);
  localparam logic [POS_W-1:0]  POS_GATE = POS_W'(GATE_START);
  localparam logic [LINE_W:0]   TGT_A = (LINE_W+1)'(EXT_LINE_A);
  localparam logic [LINE_W:0]   TGT_B = (LINE_W+1)'(EXT_LINE_B);

  logic [POS_W-1:0]  pos;
  logic [RUN_W-1:0]  run_left;
  logic [LINE_W-1:0] line_cnt;
  logic              line_ok, hs_q, ext, field, odd, active;

  logic              hs_edge, run_now, ext_now, want, supp;
  logic [LINE_W:0]   next_line, target;

  assign hs_edge   = head_sw ^ hs_q;
  assign next_line = {1'b0, line_cnt} + 1'b1;
  assign target    = field ? TGT_B : TGT_A;
  assign run_now   = run_left != '0;
  assign ext_now   = ext && (next_line < target);
  assign want      = run_now || ext_now;
  assign supp      = want || (active && odd);

  assign hpulse     = pos != POS_END;
  assign burst_gate = line_ok && hpulse && (pos >= POS_GATE);
  assign sc_code    = burst_gate ? 2'b10 : (hpulse ? 2'b01 : 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= POS_END;
      run_left <= '0;
      line_cnt <= '0;
      line_ok  <= 1'b1;
      hs_q     <= 1'b0;
      ext      <= 1'b0;
      field    <= 1'b1;
      odd      <= 1'b0;
      active   <= 1'b0;
    end else begin
      hs_q <= head_sw;
      if (pos != POS_END) pos <= pos + 1'b1;
      if (hstrobe) begin
        pos      <= '0;
        line_ok  <= !supp;
        run_left <= run_now ? run_left - 1'b1 : '0;
        ext      <= ext_now;
        odd      <= supp && !odd;
        active   <= supp;
        if (line_cnt != '1) line_cnt <= line_cnt + 1'b1;
      end
      if (vdet) begin
        line_cnt <= '0;
        field    <= !field;
        if (run_now || ext || hs_edge) ext <= 1'b1;
      end
      if (hs_edge) run_left <= RUN_W'(RUN_LINES);
    end
  end
endmodule

module burst_gate_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hstrobe,
  input logic       head_sw,
  input logic       burst_gate,
  input logic       hpulse,
  input logic [1:0] sc_code
);
  logic hs_prev, pend, blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev <= 1'b0;
      pend    <= 1'b0;
      blank   <= 1'b0;
    end else begin
      hs_prev <= head_sw;
      if (hstrobe) begin
        blank <= pend;
        pend  <= head_sw != hs_prev;
      end else if (head_sw != hs_prev) begin
        pend <= 1'b1;
      end
    end
  end

  AST_HP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    hstrobe |=> hpulse && !burst_gate); // R2
  AST_GATE_ENDS_WITH_HP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_gate) |-> $fell(hpulse)); // R3
  AST_SC_NO_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    sc_code != 2'b11); // R4
  AST_SC_HIGH_FROM_MID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sc_code[1]) |-> $past(sc_code) == 2'b01); // R4
  AST_EDGE_BLANKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !burst_gate); // R5
endmodule

bind burst_gate_seq burst_gate_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .hstrobe(hstrobe), .head_sw(head_sw),
  .burst_gate(burst_gate), .hpulse(hpulse), .sc_code(sc_code)
);

// File: tb/burst_gate_seq_test.sv
`timescale 1ns/1ps
module burst_gate_seq_test;
  localparam int LINE_LEN = 12;

  logic clk = 1'b0, rst_n = 1'b0, hstrobe = 1'b0, head_sw = 1'b0, vdet = 1'b0;
  logic burst_gate, hpulse;
  logic [1:0] sc_code;
  int checks = 0, errors = 0;

  int hcnt, gcnt, gfirst;
  logic [1:0] sc2, sc5, sc9;
  logic p7ok, p8ok;

  always #2.5 clk = ~clk;

  burst_gate_seq uut (
    .clk(clk), .rst_n(rst_n), .hstrobe(hstrobe), .head_sw(head_sw),
    .vdet(vdet), .burst_gate(burst_gate), .hpulse(hpulse), .sc_code(sc_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_line();
    hcnt = 0; gcnt = 0; gfirst = -1;
    @(negedge clk) hstrobe = 1'b1;
    @(negedge clk) hstrobe = 1'b0;
    for (int i = 0; i < LINE_LEN - 1; i++) begin
      if (hpulse) hcnt++;
      if (burst_gate) begin
        gcnt++;
        if (gfirst < 0) gfirst = i;
      end
      if (i == 2) sc2 = sc_code;
      if (i == 5) sc5 = sc_code;
      if (i == 9) sc9 = sc_code;
      if (i == 7) p7ok = burst_gate && hpulse;
      if (i == 8) p8ok = !burst_gate && !hpulse;
      if (i < LINE_LEN - 2) @(negedge clk);
    end
  endtask

  task automatic count_run(output int n, output int hbad);
    n = 0; hbad = 0;
    for (int k = 0; k < 400; k++) begin
      do_line();
      if (hcnt != 8) hbad++;
      if (gcnt != 0) break;
      n++;
    end
  endtask

  task automatic toggle_hs();
    head_sw = !head_sw;
  endtask

  task automatic pulse_vdet();
    vdet = 1'b1;
    @(negedge clk) vdet = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!burst_gate && !hpulse, "R1 outputs low in reset", {burst_gate, hpulse}, 0);
    chk(sc_code == 2'b00, "R1 sc_code in reset", sc_code, 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!burst_gate && !hpulse && sc_code == 2'b00, "R1 idle after reset", sc_code, 0);
  endtask

  task automatic t_normal();
    do_line();
    chk(hcnt == 8, "R2 hpulse width", hcnt, 8);
    chk(gcnt == 4, "R3 gate width", gcnt, 4);
    chk(gfirst == 4, "R3 gate start", gfirst, 4);
    chk(p7ok && p8ok, "R3 gate ends with hpulse", {p7ok, p8ok}, 3);
    chk(sc2 == 2'b01, "R4 intermediate level", sc2, 1);
    chk(sc5 == 2'b10, "R4 high level", sc5, 2);
    chk(sc9 == 2'b00, "R4 low level", sc9, 0);
  endtask

  task automatic t_edge(input string tag);
    int n, hb;
    @(negedge clk) toggle_hs();
    count_run(n, hb);
    chk(n == 16, {"R5 run length ", tag}, n, 16);
    chk(hb == 0, {"R2 hpulse during run ", tag}, hb, 0);
  endtask

  task automatic t_restart();
    int n, hb, first;
    first = 0;
    @(negedge clk) toggle_hs();
    for (int k = 0; k < 5; k++) begin
      do_line();
      if (gcnt == 0) first++;
    end
    chk(first == 5, "R5 lines before restart blanked", first, 5);
    @(negedge clk) toggle_hs();
    count_run(n, hb);
    chk(n == 17, "R6 R9 restart reloads run plus parity line", n, 17);
    chk(hb == 0, "R2 hpulse during restart", hb, 0);
  endtask

  task automatic t_extend_a();
    int n, hb;
    @(negedge clk) toggle_hs();
    for (int k = 0; k < 10; k++) do_line();
    @(negedge clk) pulse_vdet();
    count_run(n, hb);
    chk(n == 12, "R7 R8 R9 extension to line 12 plus parity", n, 12);
    chk(hb == 0, "R2 hpulse during extension", hb, 0);
  endtask

  task automatic t_extend_b();
    int n, hb;
    @(negedge clk) toggle_hs();
    for (int k = 0; k < 3; k++) do_line();
    @(negedge clk) pulse_vdet();
    count_run(n, hb);
    chk(n == 323, "R7 R8 extension to line 324 even total", n, 323);
    chk(hb == 0, "R2 hpulse during long extension", hb, 0);
  endtask

  task automatic t_idle_vdet();
    int g;
    g = 0;
    @(negedge clk) pulse_vdet();
    for (int k = 0; k < 3; k++) begin
      do_line();
      if (gcnt == 4) g++;
    end
    chk(g == 3, "R10 vdet without run leaves gate", g, 3);
  endtask

  task automatic t_coincident();
    int n, hb;
    @(negedge clk);
    toggle_hs();
    vdet = 1'b1;
    @(negedge clk) vdet = 1'b0;
    count_run(n, hb);
    chk(n == 324, "R7 R9 edge and vdet same cycle", n, 324);
    chk(hb == 0, "R2 hpulse during coincident run", hb, 0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_edge("rising");
    t_edge("falling");
    t_restart();
    t_extend_a();
    t_extend_b();
    t_idle_vdet();
    t_coincident();
    t_normal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule